// File: doc/BRIEF.md
# Counted-Loop Memory Summation Controller

This block walks a counted loop over an array that sits in an external single-port memory and adds the elements into a running total. A start request latches a base address and an element count. The controller then steps a one-based index from 1 up to the count. For each step it issues one read strobe at address base plus index. It waits out the memory's fixed read latency, adds the returned word to the total, and tests the loop bound again. When the index passes the bound, the total is copied to the result register and a one-cycle done pulse is raised.

The loop runs as a chain of separate states. The first clears the total and loads the index. A bound-test state comes next, then a body state that issues the read. A wait state with its own counter covers the read latency. An accumulate state adds the data and advances the index, and a finish state publishes the result. The read latency is a parameter, so one controller can serve registered block RAM or deeper pipelined memories.

Top module: `loop_sum_ctrl`

## Requirements
- R1: During and directly after synchronous reset, done and mem_rd are 0 and result is 0.
- R2: A start pulse accepted while idle latches base_addr and elem_cnt. For a count N, the controller then reads addresses base+1, base+2, ..., base+N exactly once each, in increasing order. Each read is a mem_rd strobe that is high for a single cycle.
- R3: The controller adds the mem_rdata value that is present RD_LAT cycles after the strobe cycle. Data presented in any other cycle is not used. Successive strobes are at least RD_LAT+3 cycles apart.
- R4: result is the unsigned sum of the N elements read, with DATA_W+CNT_W bits. N elements at full scale, with N at its maximum of 2^CNT_W-1, do not overflow.
- R5: An element count of 0 causes no read and completes with result 0.
- R6: done is high for exactly one cycle per loop. result takes its new value in that same cycle and holds it until the next completion.
- R7: done is high after the (2 + N*(RD_LAT+3))-th rising edge that follows the edge sampling start.
- R8: start is ignored while a loop is in progress. No further reads or done pulses follow the completion of the accepted loop.
- R9: The read address is computed modulo 2^ADDR_W, so a base near the top of the address space wraps to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop when idle |
| base_addr | input | ADDR_W | Array base address (element i at base+i) |
| elem_cnt | input | CNT_W | Number of elements to sum |
| mem_addr | output | ADDR_W | Registered memory read address |
| mem_rd | output | 1 | Registered one-cycle read strobe |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the strobe |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W+CNT_W | Sum of the elements, held between loops |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=8, CNT_W=5 and RD_LAT=3. A 64-word memory model therefore makes address wrap easy to reach. A 31-element loop of full-scale words hits the widest possible sum. The three-stage read pipeline pushes filler values through the cycles that should not be sampled, so a latency miscount changes the sum. Random counts and bases are mixed with directed runs for a zero count, the maximum count, wrap at the top of the memory and start pulses issued mid-loop.

// File: rtl/loop_sum_pkg.sv
package loop_sum_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_TEST,
    ST_BODY,
    ST_WAIT,
    ST_ACC,
    ST_FIN
  } lsum_state_t;
endpackage

// File: rtl/lsum_wait_timer.sv
module lsum_wait_timer #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int WW = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);
  localparam logic [WW-1:0] LAST = WW'(RD_LAT - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/lsum_index_unit.sv
module lsum_index_unit #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [CNT_W-1:0]  count_in,
  output logic              in_range,
  output logic [ADDR_W-1:0] addr
);
  localparam int IXW = CNT_W + 1;
  localparam int AW  = (ADDR_W > IXW) ? ADDR_W : IXW;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  bound_q;
  logic [IXW-1:0]    idx_q;
  logic [AW-1:0]     addr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      bound_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      base_q  <= base_in;
      bound_q <= count_in;
      idx_q   <= IXW'(1);
    end else if (step) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign in_range  = (idx_q <= {1'b0, bound_q});
  assign addr_full = AW'(base_q) + AW'(idx_q);
  assign addr      = addr_full[ADDR_W-1:0];
endmodule

// File: rtl/lsum_accum.sv
module lsum_accum #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [SUM_W-1:0]  sum
);
  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (add)   sum <= sum + SUM_W'(din);
  end
endmodule

// File: rtl/loop_sum_ctrl.sv
module loop_sum_ctrl
  import loop_sum_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int RD_LAT = 2,
  localparam int SUM_W = DATA_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  elem_cnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [SUM_W-1:0]  result
);
  lsum_state_t       st_q;
  logic              do_load, do_step, in_range, wait_over;
  logic [ADDR_W-1:0] next_addr;
  logic [SUM_W-1:0]  total;

  assign do_load = (st_q == ST_INIT) && start;
  assign do_step = (st_q == ST_ACC);

  lsum_index_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_idx (
    .clk(clk), .rst(rst), .load(do_load), .step(do_step),
    .base_in(base_addr), .count_in(elem_cnt),
    .in_range(in_range), .addr(next_addr)
  );

  lsum_wait_timer #(.RD_LAT(RD_LAT)) u_tmr (
    .clk(clk), .rst(rst), .clr(st_q == ST_BODY), .run(st_q == ST_WAIT),
    .expired(wait_over)
  );

  lsum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .clr(do_load), .add(do_step),
    .din(mem_rdata), .sum(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_INIT;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      mem_rd <= 1'b0;
      done   <= 1'b0;
      case (st_q)
        ST_INIT: if (start) st_q <= ST_TEST;
        ST_TEST: st_q <= in_range ? ST_BODY : ST_FIN;
        ST_BODY: begin
          mem_addr <= next_addr;
          mem_rd   <= 1'b1;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: if (wait_over) st_q <= ST_ACC;
        ST_ACC:  st_q <= ST_TEST;
        ST_FIN: begin
          result <= total;
          done   <= 1'b1;
          st_q   <= ST_INIT;
        end
        default: st_q <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/lsum_chk.sv
module lsum_chk #(
  parameter int SUM_W  = 16,
  parameter int RD_LAT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rd,
  input logic             done,
  input logic [SUM_W-1:0] result
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mem_rd) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  p_no_rd_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd);

  p_strobe_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && seen_q) |-> (gap_q >= 16'(RD_LAT + 2)));
endmodule

bind loop_sum_ctrl lsum_chk #(.SUM_W(SUM_W), .RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .done(done), .result(result)
);

// File: tb/sim_loop_sum_ctrl.sv
module sim_loop_sum_ctrl;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 5;
  localparam int RD_LAT = 3;
  localparam int SUM_W  = DATA_W + CNT_W;
  localparam int MEMN   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [CNT_W-1:0]  elem_cnt = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd;
  logic [DATA_W-1:0] mem_rdata;
  logic              done;
  logic [SUM_W-1:0]  result;

  int n_chk = 0;
  int n_bad = 0;

  logic [DATA_W-1:0] mem [MEMN];
  logic [DATA_W-1:0] pipe [RD_LAT];
  int                rd_log [64];
  int                rd_n = 0;

  always #10 clk = ~clk;

  loop_sum_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .elem_cnt(elem_cnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .result(result)
  );

  // memory model: data for a strobe appears RD_LAT cycles after the strobe cycle
  always @(posedge clk) begin
    pipe[0] <= mem_rd ? mem[mem_addr] : DATA_W'($urandom);
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign mem_rdata = pipe[RD_LAT-1];

  always @(negedge clk) begin
    if (mem_rd && rd_n < 64) begin
      rd_log[rd_n] = int'(mem_addr);
      rd_n = rd_n + 1;
    end
  end

  initial begin
    for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
    for (int i = 0; i < MEMN; i++) mem[i] = '0;
  end

  function automatic int exp_sum(int b, int n);
    int s = 0;
    for (int i = 1; i <= n; i++) s += int'(mem[(b + i) % MEMN]);
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run(int b, int n, bit poke);
    int cyc;
    int es;
    int addr_ok;
    int quiet_ok;
    es = exp_sum(b, n);
    rd_n = 0;
    @(negedge clk);
    start = 1'b1; base_addr = ADDR_W'(b); elem_cnt = CNT_W'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      // R8: a start issued mid-loop must be ignored
      if (poke && cyc == 2) begin
        start = 1'b1; base_addr = ADDR_W'($urandom); elem_cnt = CNT_W'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == 3 + n * (RD_LAT + 3), "R7 latency", cyc, 3 + n * (RD_LAT + 3));
    check(int'(result) == es, "R4 sum", int'(result), es);
    if (n == 0) check(rd_n == 0 && result == '0, "R5 zero count", rd_n, 0);
    check(rd_n == n, "R2 read count", rd_n, n);
    addr_ok = 1;
    for (int i = 0; i < rd_n && i < n; i++)
      if (rd_log[i] != (b + i + 1) % MEMN) addr_ok = 0;
    check(addr_ok == 1, "R2/R9 addresses", addr_ok, 1);
    quiet_ok = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || mem_rd) quiet_ok = 0;
    end
    check(quiet_ok == 1, "R8 no extra activity", quiet_ok, 1);
    check(int'(result) == es, "R6 result held", int'(result), es);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !mem_rd && result == '0, "R1 reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !mem_rd && result == '0, "R1 after reset", int'(result), 0);

    for (int i = 0; i < MEMN; i++) mem[i] = DATA_W'($urandom);
    run(10, 0, 1'b0);                           // R5 zero count
    run(5, 1, 1'b0);                            // R3 single element
    for (int i = 0; i < MEMN; i++) mem[i] = '1;
    run(0, (1 << CNT_W) - 1, 1'b0);             // R4 full scale, max count
    for (int i = 0; i < MEMN; i++) mem[i] = DATA_W'($urandom);
    run(MEMN - 3, 7, 1'b0);                     // R9 wrap
    run(20, 4, 1'b1);                           // R8 mid-loop start
    run(40, 0, 1'b1);                           // R8 poke on zero count
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < MEMN; i++) mem[i] = DATA_W'($urandom);
      run(int'($urandom % MEMN), int'($urandom % (1 << CNT_W)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule